// File: doc/BRIEF.md
# Multiplexed-Bus Read Cycle Sequencer

This block is a bus master that runs read machine cycles on an external bus whose low address byte and data byte share one set of pins. A client presents a 16-bit address with a request. The sequencer strobes an address-latch-enable pulse so that an external latch can capture the low byte. It drives the high byte on its own lines and lowers an active-low read strobe. It then waits on a READY input and returns the byte read together with a one-phase done pulse.

The block runs on one clock at twice the bus rate. Each clock period is one half of a bus clock, and an internal phase bit gives the bus clock itself (`bus_clk`). Because every event on the bus is placed on a half-clock boundary, it lands on a definite edge of the fast clock. The shared lines appear as separate output, input and output-enable ports, so that a pad ring or a bench can resolve them. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset on the third rising edge after `rst_n` goes high.

Top module: `mbr_read_seq`

## Requirements
- R1: While in reset and until the first request: `ale`=0, `rd_n`=1, `ad_oe`=0, `busy`=0, `done`=0, `bus_clk`=0 and `rdata`=0.
- R2: A request (`req`=1) is taken only at a rising edge where `bus_clk` is 0 and the block is not busy. In the phase that follows, `ale` is 1 and `bus_clk` is 1. `ale` stays high for exactly one phase.
- R3: The low address byte is on `ad_out` with `ad_oe`=1 during the `ale` phase and the phase after it. The high address byte is on `addr_hi` and does not change from acceptance until done.
- R4: `rd_n` falls exactly one phase after `ale` falls. `ad_oe` is 0 for every phase in which `rd_n` is 0.
- R5: READY is sampled at the edge where `rd_n` falls, and again every two phases while it was found low. Values of READY between those sampling edges have no effect.
- R6: If READY is found low k times before it is found high, `rd_n` stays low for exactly 3+2k phases.
- R7: `ad_in` is captured at the edge two phases after the sampling edge that found READY high. In the phase where `rd_n` returns high, `done` is 1 for that one phase and `rdata` holds the captured byte. `rdata` keeps that value until the next capture.
- R8: `busy` is 1 from the phase after acceptance until the done phase, and 0 in the done phase. A request present while `busy`=1 is ignored: `addr_hi` and `ad_out` keep the accepted address.
- R9: A request present during the done phase is accepted at the end of that phase. The next `ale` therefore rises one phase after `rd_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate; one period is one phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request |
| req_addr | input | 16 | Address of the requested read |
| busy | output | 1 | Cycle in progress; requests are ignored |
| done | output | 1 | One-phase pulse, `rdata` valid |
| rdata | output | 8 | Byte captured from the bus |
| ready | input | 1 | Target ready; low inserts wait states |
| ale | output | 1 | Address latch enable strobe |
| rd_n | output | 1 | Active-low read strobe |
| ad_out | output | 8 | Shared lines, driven value (low address byte) |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Shared lines, received value |
| addr_hi | output | 8 | Dedicated high address byte |
| bus_clk | output | 1 | Bus clock derived from the phase bit |

## Verification
The assertions assume that `ready` and `ad_in` are stable across each rising clock edge. They also assume that `req_addr` is stable while `req` is held. The bench drives every input only at falling edges, which meets both assumptions. It holds a request until `busy` is seen and raises READY from a count of strobe-low phases, so the number of wait states is exactly the number requested. In its noise mode the bench pulses READY only on phases that are not sampling edges, so any pulse the block obeys shows up as a wrong strobe length.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE_HI,
    ST_ALE_LO,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } mbr_state_e;

endpackage

// File: rtl/mbr_rst_sync.sv
module mbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbr_phase.sv
module mbr_phase (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);

  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R2: the phase bit must alternate on every edge out of reset
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> !phase_q);

endmodule

// File: rtl/mbr_seq_fsm.sv
module mbr_seq_fsm
  import mbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase,
  input  logic       req,
  input  logic       ready,
  output mbr_state_e state,
  output logic       accept,
  output logic       capture
);

  mbr_state_e state_q, state_d;
  logic       half_q, half_d;
  logic       rdy_ok_q, rdy_ok_d;
  logic       can_take;

  always_comb begin
    can_take = (state_q == ST_IDLE) || (state_q == ST_RECOVER);
    accept   = can_take && req && !phase;
  end

  always_comb begin
    state_d  = state_q;
    half_d   = half_q;
    rdy_ok_d = rdy_ok_q;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_ALE_HI;
      end
      ST_ALE_HI: state_d = ST_ALE_LO;
      ST_ALE_LO: begin
        state_d  = ST_STROBE;
        half_d   = 1'b0;
        rdy_ok_d = ready;
      end
      ST_STROBE: begin
        if (!half_q) begin
          half_d = 1'b1;
        end else if (rdy_ok_q) begin
          capture = 1'b1;
          state_d = ST_HOLD;
        end else begin
          half_d   = 1'b0;
          rdy_ok_d = ready;
        end
      end
      ST_HOLD: state_d = ST_RECOVER;
      ST_RECOVER: begin
        state_d = accept ? ST_ALE_HI : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      half_q   <= 1'b0;
      rdy_ok_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      half_q   <= half_d;
      rdy_ok_q <= rdy_ok_d;
    end
  end

  assign state = state_q;

  // R5: a wait state found low keeps the strobe phase going for one more full clock
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STROBE && half_q && !rdy_ok_q) |=> (state_q == ST_STROBE && !half_q));

  // R2: a cycle only begins on the low half of the bus clock
  p_start_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALE_HI) |-> phase);

endmodule

// File: rtl/mbr_ad_path.sv
module mbr_ad_path
  import mbr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mbr_state_e        state,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic [HI_W-1:0]   addr_hi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    addr_d = accept  ? req_addr : addr_q;
    data_d = capture ? ad_in    : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    ale   = (state == ST_ALE_HI);
    ad_oe = (state == ST_ALE_HI) || (state == ST_ALE_LO);
    rd_n  = !((state == ST_STROBE) || (state == ST_HOLD));
    done  = (state == ST_RECOVER);
    busy  = (state != ST_IDLE) && (state != ST_RECOVER);
  end

  assign ad_out  = addr_q[DATA_W-1:0];
  assign addr_hi = addr_q[ADDR_W-1:DATA_W];
  assign rdata   = data_q;

  // R2: the latch strobe lasts one phase and the address is still driven after it
  p_ale_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && ad_oe));

  // R4: the read strobe falls exactly one phase after the latch strobe falls
  p_rd_after_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(ale, 2) && !$past(ale)));

  // R4: the shared lines are released while the read strobe is low
  p_float_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R3: the high address byte holds for the whole cycle
  p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_hi));

  // R7: done marks the phase where the read strobe returns high, for one phase
  p_done_with_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(rd_n) && $stable(rdata)));

endmodule

// File: rtl/mbr_read_seq.sv
module mbr_read_seq
  import mbr_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W       = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  input  logic              ready,
  output logic              ale,
  output logic              rd_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic              bus_clk
);

  logic       rst_int_n;
  logic       phase;
  logic       accept;
  logic       capture;
  mbr_state_e state;

  mbr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mbr_phase u_phase (
    .clk   (clk),
    .rst_n (rst_int_n),
    .phase (phase)
  );

  mbr_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .phase   (phase),
    .req     (req),
    .ready   (ready),
    .state   (state),
    .accept  (accept),
    .capture (capture)
  );

  mbr_ad_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ad_path (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .state    (state),
    .accept   (accept),
    .capture  (capture),
    .req_addr (req_addr),
    .ad_in    (ad_in),
    .ale      (ale),
    .rd_n     (rd_n),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out),
    .addr_hi  (addr_hi),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata)
  );

  assign bus_clk = phase;

  // R8: busy rises only together with the latch strobe
  p_busy_starts_cycle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> (ale && bus_clk));

endmodule

// File: tb/test_mbr_read_seq.sv
`timescale 1ns/1ps
module test_mbr_read_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] req_addr = '0;
  logic        busy, done, ale, rd_n, ad_oe, bus_clk;
  logic [7:0]  rdata, ad_out, addr_hi;
  logic [7:0]  ad_in;
  logic        ready;

  int  vectors = 0;
  int  miscompares = 0;
  int  cycles = 0;
  int  lowrun = 0;
  int  cur_k = 0;
  bit  noise = 1'b0;
  logic [7:0] cur_data = 8'h00;
  int  q_k[$];
  logic [7:0] q_d[$];
  bit  q_n[$];

  always #2 clk = ~clk;

  assign ad_in = cur_data;
  assign ready = (lowrun >= 2 * cur_k) || (noise && lowrun[0]);

  mbr_read_seq i_mbr_read_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .busy(busy), .done(done), .rdata(rdata), .ready(ready),
    .ale(ale), .rd_n(rd_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .addr_hi(addr_hi), .bus_clk(bus_clk)
  );

  // behavioural reference: edge index p since acceptance, edge es where READY was seen high
  int  rcnt = 0;
  int  p = 0;
  int  es = -1;
  bit  act = 1'b0;
  bit  mph = 1'b0;
  logic [15:0] maddr = '0;
  logic [7:0]  mdata = '0;

  always @(posedge clk) begin : model
    bit m_done, m_busy, acc;
    if (!rst_n) begin
      rcnt = 0; act = 1'b0; mph = 1'b0; maddr = '0; mdata = '0;
    end else if (rcnt < 2) begin
      rcnt++; act = 1'b0; mph = 1'b0;
    end else begin
      m_done = act && (es >= 0) && (p == es + 3);
      m_busy = act && !m_done;
      acc    = req && !m_busy && !mph;
      if (act) begin
        p++;
        if (es < 0 && p >= 2 && (p % 2) == 0 && ready) es = p;
        if (es >= 0 && p == es + 2) mdata = ad_in;
        if (es >= 0 && p == es + 4) act = 1'b0;
      end
      if (acc) begin
        act = 1'b1; p = 0; es = -1; maddr = req_addr;
      end
      mph = !mph;
    end
  end

  task automatic cmp(input string tag, input logic [15:0] got, input logic [15:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h exp %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // per-phase comparison against the model, away from the active edge
  always @(negedge clk) begin : compare
    bit e_ale, e_oe, e_rdn, e_done, e_busy;
    cycles++;
    if (rst_n && rcnt >= 2) begin
      e_ale  = act && p == 0;
      e_oe   = act && p <= 1;
      e_rdn  = !(act && p >= 2 && (es < 0 || p <= es + 2));
      e_done = act && es >= 0 && p == es + 3;
      e_busy = act && !e_done;
      vectors++;
      cmp("R2 ale", {15'd0, ale}, {15'd0, e_ale});
      cmp("R2 bus_clk", {15'd0, bus_clk}, {15'd0, mph});
      cmp("R3 ad_oe", {15'd0, ad_oe}, {15'd0, e_oe});
      if (e_oe) cmp("R3 ad_out", {8'd0, ad_out}, {8'd0, maddr[7:0]});
      if (act)  cmp("R3 addr_hi", {8'd0, addr_hi}, {8'd0, maddr[15:8]});
      cmp("R4 rd_n", {15'd0, rd_n}, {15'd0, e_rdn});
      cmp("R7 done", {15'd0, done}, {15'd0, e_done});
      cmp("R8 busy", {15'd0, busy}, {15'd0, e_busy});
      if (e_done) cmp("R7 rdata", {8'd0, rdata}, {8'd0, mdata});
    end
  end

  // transaction monitor: strobe-low length and captured byte
  always @(negedge clk) begin : monitor
    int k; logic [7:0] d; bit n;
    if (!rd_n) lowrun++;
    else begin
      if (done && q_k.size() > 0) begin
        k = q_k.pop_front(); d = q_d.pop_front(); n = q_n.pop_front();
        vectors++;
        if (lowrun != 3 + 2 * k) begin
          miscompares++;
          $display("FAIL %s: strobe-low phases got %0d exp %0d", n ? "R5" : "R6", lowrun, 3 + 2 * k);
        end
        vectors++;
        if (rdata !== d) begin
          miscompares++;
          $display("FAIL R7: rdata got %0h exp %0h", rdata, d);
        end
      end
      lowrun = 0;
    end
  end

  task automatic issue(input logic [15:0] a, input logic [7:0] d, input int k, input bit n);
    cur_k = k; cur_data = d; noise = n;
    q_k.push_back(k); q_d.push_back(d); q_n.push_back(n);
    req = 1'b1; req_addr = a;
    do @(negedge clk); while (!busy);
    req = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] d, input int k, input bit n);
    @(negedge clk);
    issue(a, d, k, n);
    wait_done();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: outputs in reset
    vectors++;
    if ({ale, rd_n, ad_oe, busy, done, bus_clk} !== 6'b010000 || rdata !== 8'h00) begin
      miscompares++;
      $display("FAIL R1: got %b/%0h exp 010000/0", {ale, rd_n, ad_oe, busy, done, bus_clk}, rdata);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vectors++;
    if ({ale, rd_n, busy, done} !== 4'b0100) begin
      miscompares++;
      $display("FAIL R1: idle after reset got %b exp 0100", {ale, rd_n, busy, done});
    end

    do_read(16'h12A5, 8'h3C, 0, 1'b0);   // R6 no wait state
    do_read(16'hBE01, 8'hC3, 1, 1'b0);   // R6 one wait state
    do_read(16'h7F80, 8'h5A, 4, 1'b0);   // R6 several wait states
    do_read(16'h0000, 8'hFF, 2, 1'b1);   // R5 READY pulses between samples

    // R8: request with another address while busy is ignored
    @(negedge clk);
    issue(16'hA55A, 8'h81, 3, 1'b0);
    repeat (2) @(negedge clk);
    req = 1'b1; req_addr = 16'h1111;
    repeat (5) @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    vectors++;
    if (busy !== 1'b0) begin
      miscompares++;
      $display("FAIL R8: busy after ignored request got %b exp 0", busy);
    end

    // R9: back-to-back, next request presented in the done phase
    @(negedge clk);
    issue(16'h4321, 8'h99, 1, 1'b0);
    wait_done();
    issue(16'hFEDC, 8'h66, 0, 1'b0);
    vectors++;
    if (ale !== 1'b1) begin
      miscompares++;
      $display("FAIL R9: ale one phase after done got %b exp 1", ale);
    end
    wait_done();
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule